// File: doc/BRIEF.md
# Conversion Sample Buffer with Conversion Counter

This block sits between an analog-to-digital converter and a host data port. Each time the converter pulses its conversion-done strobe, the block packs the 12-bit result and a 4-bit channel tag into one 16-bit word and stores it in a first-in first-out buffer of 1024 entries. The host removes words one at a time through a read strobe and sees them on a 16-bit data output.

Alongside the buffer runs a 16-bit conversion down-counter. The host can load it with a start value. The load is held back until the next conversion, and from then on every conversion takes one off the count. Software compares the value it loaded with the current count to work out how many samples have been produced. It learns the buffer's fill level only that way.

An 8-bit status byte carries a data-ready flag and a sticky overrun flag. The data-ready flag is set by every conversion and cleared by the host. The overrun flag records that a sample arrived while the buffer was full.

Top module: `adc_sample_fifo`

## Requirements
- R1: The buffer holds up to 1024 words and returns them in the order they were captured.
- R2: A stored word carries the 12-bit sample in bits 15:4 and the 4-bit channel tag in bits 3:0.
- R3: A one-cycle `rd_data` pulse on a non-empty buffer puts the oldest word on `data_out` at the next clock edge. `data_out` holds its value in every other cycle.
- R4: A read of an empty buffer leaves `data_out` at its last value and does not move the buffer state. The next captured sample is the next word read.
- R5: A conversion that arrives while the buffer holds 1024 words, with no read in the same cycle, is discarded. It also sets status bit 5 (overrun), which then stays set until reset.
- R6: Every conversion sets status bit 7 (data ready), and a `drdy_clr` pulse clears it. If both happen in the same cycle the flag is set. All other status bits read 0.
- R7: Each conversion decrements `cnt_value` by one, and a decrement from 0x0000 gives 0xFFFF.
- R8: A value written with `cnt_wr` does not appear on `cnt_value` until the next conversion. That conversion loads the value and does not decrement it. Until then `cnt_value` keeps its old value.
- R9: A synchronous `rst` empties the buffer and clears both flags. It also sets `data_out` and `cnt_value` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | Conversion-done strobe, one cycle per sample |
| conv_sample | input | 12 | Converted sample value |
| conv_tag | input | 4 | Channel tag of the sample |
| rd_data | input | 1 | Host read strobe, pops one word |
| data_out | output | 16 | Last word popped |
| cnt_wr | input | 1 | Host write strobe for the counter start value |
| cnt_wdata | input | 16 | Counter start value |
| cnt_value | output | 16 | Current conversion count |
| drdy_clr | input | 1 | Clears the data-ready flag |
| status | output | 8 | Bit 7 data ready, bit 5 overrun, others 0 |

## Verification
The bench fills the buffer to exactly 1024 words and then adds one more sample. A design with an off-by-one limit would either raise overrun too early or overwrite the oldest word. The drain that follows shows which, because the first and last words are checked. Reading past empty confirms that the output holds its value and does not show stale memory from a wrapped pointer. The counter tests cover the wrap below zero and the deferred load. A design that loaded at once, or that also decremented on the loading conversion, would show the wrong count one step too early or one off.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
   localparam int ST_W     = 8;
   localparam int ST_DRDY  = 7;
   localparam int ST_OVR   = 5;

   typedef struct packed {
      logic drdy;
      logic ovr;
   } flags_t;
endpackage

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
   parameter int DEPTH = 1024,
   parameter int W     = 16,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LVL_W  = ADDR_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [LVL_W-1:0] level,
   output logic             drop
);
   logic [W-1:0]      mem [DEPTH];
   logic [ADDR_W-1:0] wptr, rptr;
   logic              full, empty, do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign drop    = push && full && !do_pop;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
         dout  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop) begin
            dout <= mem[rptr];
            rptr <= rptr + 1'b1;
         end
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/adc_conv_counter.sv
module adc_conv_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             ld_we,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] count,
   output logic             pend
);
   logic [CNT_W-1:0] pend_val;

   always_ff @(posedge clk) begin
      if (rst) begin
         count    <= '0;
         pend     <= 1'b0;
         pend_val <= '0;
      end else begin
         if (tick) begin
            if (pend) begin
               count <= pend_val;
               pend  <= 1'b0;
            end else begin
               count <= count - 1'b1;
            end
         end
         if (ld_we) begin
            pend_val <= ld_val;
            pend     <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/adc_status_flags.sv
module adc_status_flags
   import adc_fifo_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic            conv,
   input  logic            drop,
   input  logic            clr,
   output logic [ST_W-1:0] status
);
   flags_t fl;

   always_ff @(posedge clk) begin
      if (rst) begin
         fl <= '0;
      end else begin
         fl.drdy <= conv ? 1'b1 : (clr ? 1'b0 : fl.drdy);
         fl.ovr  <= fl.ovr | drop;
      end
   end

   always_comb begin
      for (int b = 0; b < ST_W; b++) begin
         if (b == ST_DRDY)     status[b] = fl.drdy;
         else if (b == ST_OVR) status[b] = fl.ovr;
         else                  status[b] = 1'b0;
      end
   end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
   import adc_fifo_pkg::*;
#(
   parameter int DEPTH    = 1024,
   parameter int SAMPLE_W = 12,
   parameter int TAG_W    = 4,
   parameter int CNT_W    = 16,
   parameter bit TAG_LOW  = 1'b1,
   localparam int WORD_W  = SAMPLE_W + TAG_W,
   localparam int LVL_W   = $clog2(DEPTH) + 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                conv_done,
   input  logic [SAMPLE_W-1:0] conv_sample,
   input  logic [TAG_W-1:0]    conv_tag,
   input  logic                rd_data,
   output logic [WORD_W-1:0]   data_out,
   input  logic                cnt_wr,
   input  logic [CNT_W-1:0]    cnt_wdata,
   output logic [CNT_W-1:0]    cnt_value,
   input  logic                drdy_clr,
   output logic [ST_W-1:0]     status
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (SAMPLE_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("SAMPLE_W and TAG_W must be positive");
   end

   logic [WORD_W-1:0] packed_word;
   logic [LVL_W-1:0]  fill_lvl;
   logic              drop;
   logic              load_pend;

   if (TAG_LOW) begin : g_tag_low
      assign packed_word = {conv_sample, conv_tag};
   end else begin : g_tag_high
      assign packed_word = {conv_tag, conv_sample};
   end

   adc_fifo_store #(.DEPTH(DEPTH), .W(WORD_W)) i_store (
      .clk   (clk),
      .rst   (rst),
      .push  (conv_done),
      .din   (packed_word),
      .pop   (rd_data),
      .dout  (data_out),
      .level (fill_lvl),
      .drop  (drop)
   );

   adc_conv_counter #(.CNT_W(CNT_W)) i_count (
      .clk    (clk),
      .rst    (rst),
      .tick   (conv_done),
      .ld_we  (cnt_wr),
      .ld_val (cnt_wdata),
      .count  (cnt_value),
      .pend   (load_pend)
   );

   adc_status_flags i_flags (
      .clk    (clk),
      .rst    (rst),
      .conv   (conv_done),
      .drop   (drop),
      .clr    (drdy_clr),
      .status (status)
   );
endmodule

// File: rtl/adc_fifo_chk.sv
module adc_fifo_chk #(
   parameter int DEPTH  = 1024,
   parameter int WORD_W = 16,
   parameter int CNT_W  = 16,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              conv_done,
   input logic              rd_data,
   input logic              drdy_clr,
   input logic [WORD_W-1:0] data_out,
   input logic [CNT_W-1:0]  cnt_value,
   input logic [7:0]        status,
   input logic [LVL_W-1:0]  level,
   input logic              load_pend
);
   p_level_bound_r1: assert property (@(posedge clk) disable iff (rst)
      level <= LVL_W'(DEPTH));

   p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
      !rd_data |=> $stable(data_out));

   p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
      (level == '0 && rd_data && !conv_done) |=> (level == '0 && $stable(data_out)));

   p_ovr_set_r5: assert property (@(posedge clk) disable iff (rst)
      (level == LVL_W'(DEPTH) && conv_done && !rd_data) |=> status[5]);

   p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      status[5] |=> status[5]);

   p_full_no_grow_r5: assert property (@(posedge clk) disable iff (rst)
      (level == LVL_W'(DEPTH) && !rd_data) |=> level == LVL_W'(DEPTH));

   p_drdy_set_r6: assert property (@(posedge clk) disable iff (rst)
      conv_done |=> status[7]);

   p_drdy_clr_r6: assert property (@(posedge clk) disable iff (rst)
      (drdy_clr && !conv_done) |=> !status[7]);

   p_cnt_dec_r7: assert property (@(posedge clk) disable iff (rst)
      (conv_done && !load_pend) |=> cnt_value == $past(cnt_value) - 1'b1);

   p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !conv_done |=> $stable(cnt_value));
endmodule

bind adc_sample_fifo adc_fifo_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .conv_done (conv_done),
   .rd_data   (rd_data),
   .drdy_clr  (drdy_clr),
   .data_out  (data_out),
   .cnt_value (cnt_value),
   .status    (status),
   .level     (fill_lvl),
   .load_pend (load_pend)
);

// File: tb/test_adc_sample_fifo.sv
`timescale 1ns/1ps
module test_adc_sample_fifo;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        conv_done = 1'b0;
   logic [11:0] conv_sample = '0;
   logic [3:0]  conv_tag = '0;
   logic        rd_data = 1'b0;
   logic [15:0] data_out;
   logic        cnt_wr = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic [15:0] cnt_value;
   logic        drdy_clr = 1'b0;
   logic [7:0]  status;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   adc_sample_fifo i_adc_sample_fifo (
      .clk(clk), .rst(rst), .conv_done(conv_done), .conv_sample(conv_sample),
      .conv_tag(conv_tag), .rd_data(rd_data), .data_out(data_out),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_value(cnt_value),
      .drdy_clr(drdy_clr), .status(status)
   );

   // {sample[11:0], tag[3:0], expected word[15:0]}
   localparam logic [31:0] VEC [8] = '{
      {12'h000, 4'h0, 16'h0000},
      {12'hFFF, 4'hF, 16'hFFFF},
      {12'hA5A, 4'h3, 16'hA5A3},
      {12'h123, 4'hC, 16'h123C},
      {12'h800, 4'h1, 16'h8001},
      {12'h001, 4'h8, 16'h0018},
      {12'h7FE, 4'h6, 16'h7FE6},
      {12'h3C4, 4'hA, 16'h3C4A}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic conv(input logic [11:0] s, input logic [3:0] t);
      @(negedge clk); conv_done = 1'b1; conv_sample = s; conv_tag = t;
      @(negedge clk); conv_done = 1'b0;
   endtask

   task automatic pop();
      @(negedge clk); rd_data = 1'b1;
      @(negedge clk); rd_data = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R9 reset state
      check("R9 data_out after reset", data_out, 16'h0000);
      check("R9 status after reset", {8'h00, status}, 16'h0000);
      check("R9 count after reset", cnt_value, 16'h0000);

      // R1 R2 R3: table walk, order and packing
      for (int i = 0; i < 8; i++) conv(VEC[i][31:20], VEC[i][19:16]);
      check("R6 drdy after conversions", {8'h00, status}, 16'h0080);
      for (int i = 0; i < 8; i++) begin
         pop();
         check("R2 packed word in order", data_out, VEC[i][15:0]);
         @(negedge clk);
         check("R3 data_out holds", data_out, VEC[i][15:0]);
      end

      // R4 empty read keeps last value; next sample is next word
      pop();
      check("R4 empty read holds", data_out, 16'h3C4A);
      conv(12'h5B1, 4'h2);
      pop();
      check("R4 sample after empty read", data_out, 16'h5B12);

      // R7 R8 counter
      do_reset();
      conv(12'h001, 4'h1);
      check("R7 wrap to FFFF", cnt_value, 16'hFFFF);
      conv(12'h002, 4'h2);
      check("R7 decrement", cnt_value, 16'hFFFE);
      @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 16'h0010;
      @(negedge clk); cnt_wr = 1'b0;
      @(negedge clk);
      check("R8 old value before conversion", cnt_value, 16'hFFFE);
      conv(12'h003, 4'h3);
      check("R8 load on conversion", cnt_value, 16'h0010);
      conv(12'h004, 4'h4);
      check("R7 decrement after load", cnt_value, 16'h000F);

      // R5 fill to capacity, then overflow
      do_reset();
      for (int i = 0; i < 1024; i++) conv(12'(i), 4'(i));
      check("R5 no overrun at exactly full", {8'h00, status}, 16'h0080);
      conv(12'hABC, 4'hD);
      check("R5 overrun set", {8'h00, status}, 16'h00A0);
      for (int i = 0; i < 1024; i++) begin
         pop();
         if (i == 0 || i == 1023 || i == 512)
            check("R1 drain order", data_out, {12'(i), 4'(i)});
      end
      pop();
      check("R5 dropped sample not stored", data_out, 16'h3FFF);
      check("R5 overrun sticky", {8'h00, status}, 16'h00A0);

      // R6 data-ready clear and priority
      @(negedge clk); drdy_clr = 1'b1;
      @(negedge clk); drdy_clr = 1'b0;
      check("R6 drdy cleared", {8'h00, status}, 16'h0020);
      @(negedge clk); drdy_clr = 1'b1; conv_done = 1'b1; conv_sample = 12'h111; conv_tag = 4'h1;
      @(negedge clk); drdy_clr = 1'b0; conv_done = 1'b0;
      check("R6 set wins over clear", {8'h00, status}, 16'h00A0);

      // R9 reset clears overrun and empties buffer
      do_reset();
      check("R9 flags cleared", {8'h00, status}, 16'h0000);
      pop();
      check("R9 buffer empty after reset", data_out, 16'h0000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule